// File: doc/BRIEF.md
# SEC-DED Protected Byte Memory

This block is a small synchronous word memory. Every byte written into it is stored as a 13-bit codeword: a 12-bit Hamming code with check bits at the power-of-two positions, plus an overall parity bit. On a read, the stored codeword goes through syndrome decoding. A single flipped bit anywhere in the 13 bits is repaired before the byte is returned. Two flipped bits are reported but not repaired.

A select input enables the unit, and a read/write input picks the operation. Read results are registered. The corrected byte and two status flags appear one clock after a selected read, together with a one-cycle valid strobe. For testing the protection logic, an injection port XORs a chosen 13-bit mask into the codeword held at the addressed location.

Top module: `ecc_word_mem`

## Requirements
- R1: The stored codeword is indexed by mask bit i-1 for positions 1 to 12, and mask bit 12 is the overall parity bit. Data bit 7 sits at position 3. Bits 6, 5 and 4 sit at positions 5, 6 and 7. Bits 3 to 0 sit at positions 9 to 12. Check bits sit at positions 1, 2, 4 and 8, each giving even parity over the positions whose index has that binary bit set. The overall bit is the XOR of the other 12 bits.
- R2: A selected write (`sel`=1, `wr`=1) followed by a selected read (`sel`=1, `wr`=0) of the same address returns the written byte with both flags low, with no injection in between.
- R3: With one of positions 1 to 12 flipped, a read returns the original byte with `sec_err`=1 and `ded_err`=0. The 4-bit syndrome {C8,C4,C2,C1} equals the flipped position.
- R4: When only the overall parity bit is flipped, a read returns the original byte with `sec_err`=1 and `ded_err`=0.
- R5: With a nonzero syndrome and even overall parity (two flips), a read sets `ded_err`=1 and `sec_err`=0, and returns the stored data bits without modification.
- R6: A syndrome of 13, 14 or 15 with odd overall parity names no position. It is reported with `ded_err`=1 and `sec_err`=0, and the stored data bits are returned unmodified.
- R7: `rvalid` is high for exactly the cycle after each selected read, and `rdata`/flags update only on that cycle. Writes and idle cycles leave `rvalid` low.
- R8: While `sel` is low, no write reaches the array, and `rdata`, `sec_err` and `ded_err` hold their values.
- R9: Reset clears `rdata`, `rvalid`, `sec_err` and `ded_err`, but keeps the array contents.
- R10: With `inj_en`=1, the mask is XORed into the codeword at `addr`. When a selected write occurs in the same cycle, the write wins and the injection is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Unit select |
| wr | input | 1 | 1 = write, 0 = read (when selected) |
| addr | input | ADDR_W | Word address |
| wdata | input | 8 | Write byte |
| inj_en | input | 1 | Apply injection mask to the addressed word |
| inj_mask | input | 13 | Bits to flip (bit i-1 = position i, bit 12 = overall parity) |
| rdata | output | 8 | Returned byte |
| rvalid | output | 1 | One-cycle read strobe |
| sec_err | output | 1 | Single error seen and handled |
| ded_err | output | 1 | Uncorrectable error seen |

## Verification
The hardest case to reach from the ports is the invalid-syndrome case: three flips whose positions XOR to 13, 14 or 15. No single or double upset can produce it. The stimulus builds it by injecting masks over check-bit positions only (1, 4 and 8, then 2, 4 and 8). This gives syndromes 13 and 14 with odd parity and untouched data bits, so any attempt at correction would show up as a corrupted byte. Double flips on data positions expose the raw stored bits, and this confirms the codeword layout from the outside.

// File: rtl/ecc_mem_pkg.sv
package ecc_mem_pkg;

    localparam int DATA_W = 8;
    localparam int HAM_W  = 12;
    localparam int CW_W   = HAM_W + 1;
    localparam int SYN_W  = 4;

    typedef logic [CW_W-1:0]   codeword_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [SYN_W-1:0]  syndrome_t;

    typedef enum logic [1:0] {
        ST_CLEAN   = 2'd0,
        ST_SINGLE  = 2'd1,
        ST_OVERALL = 2'd2,
        ST_DOUBLE  = 2'd3
    } rd_status_e;

    typedef struct packed {
        byte_t      data;
        rd_status_e status;
    } rd_result_t;

    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Place data bits MSB-first into non-power-of-two positions, then fill
    // check bits with even parity and append overall parity in bit 12.
    function automatic codeword_t encode(input byte_t d);
        logic [HAM_W:1] pos;
        int k;
        pos = '0;
        k = DATA_W - 1;
        for (int p = 1; p <= HAM_W; p++) begin
            if (!is_pow2(p)) begin
                pos[p] = d[k];
                k--;
            end
        end
        for (int b = 0; b < SYN_W; b++) begin
            logic acc;
            acc = 1'b0;
            for (int p = 1; p <= HAM_W; p++) begin
                if (((p >> b) & 1) == 1 && p != (1 << b)) acc ^= pos[p];
            end
            pos[1 << b] = acc;
        end
        return {^pos, pos};
    endfunction

    function automatic syndrome_t syndrome(input codeword_t cw);
        syndrome_t s;
        for (int b = 0; b < SYN_W; b++) begin
            logic acc;
            acc = 1'b0;
            for (int p = 1; p <= HAM_W; p++) begin
                if (((p >> b) & 1) == 1) acc ^= cw[p-1];
            end
            s[b] = acc;
        end
        return s;
    endfunction

    function automatic byte_t extract(input codeword_t cw);
        byte_t d;
        int k;
        d = '0;
        k = DATA_W - 1;
        for (int p = 1; p <= HAM_W; p++) begin
            if (!is_pow2(p)) begin
                d[k] = cw[p-1];
                k--;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
    import ecc_mem_pkg::*;
(
    input  byte_t     data_in,
    output codeword_t cw_out
);
    always_comb cw_out = encode(data_in);
endmodule

// File: rtl/ecc_storage.sv
module ecc_storage
    import ecc_mem_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] addr,
    input  codeword_t         wr_cw,
    input  codeword_t         inj_mask,
    output codeword_t         rd_cw
);
    localparam int DEPTH = 1 << ADDR_W;

    codeword_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wr_cw;
        end else if (inj_en) begin
            mem[addr] <= mem[addr] ^ inj_mask;
        end
    end

    always_comb rd_cw = mem[addr];
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
    import ecc_mem_pkg::*;
(
    input  codeword_t  cw_in,
    output rd_result_t result,
    output byte_t      raw_data
);
    localparam int MAX_POS = HAM_W;

    syndrome_t syn;
    logic      odd;
    codeword_t fixed;

    always_comb begin
        syn      = syndrome(cw_in);
        odd      = ^cw_in;
        raw_data = extract(cw_in);
        fixed    = cw_in;
        result.data   = raw_data;
        result.status = ST_CLEAN;
        if (syn == '0) begin
            if (odd) result.status = ST_OVERALL;
        end else if (odd && int'(syn) <= MAX_POS) begin
            fixed[int'(syn) - 1] = ~cw_in[int'(syn) - 1];
            result.data   = extract(fixed);
            result.status = ST_SINGLE;
        end else begin
            result.status = ST_DOUBLE;
        end
    end
endmodule

// File: rtl/ecc_word_mem.sv
module ecc_word_mem
    import ecc_mem_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              inj_en,
    input  logic [12:0]       inj_mask,
    output logic [7:0]        rdata,
    output logic              rvalid,
    output logic              sec_err,
    output logic              ded_err
);
    codeword_t  enc_cw;
    codeword_t  stored_cw;
    rd_result_t dec_res;
    byte_t      dec_raw;
    logic       do_write;
    logic       do_read;

    always_comb do_write = sel && wr;
    always_comb do_read  = sel && !wr;

    ecc_encoder u_enc (
        .data_in (wdata),
        .cw_out  (enc_cw)
    );

    ecc_storage #(.ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .wr_en    (do_write),
        .inj_en   (inj_en),
        .addr     (addr),
        .wr_cw    (enc_cw),
        .inj_mask (inj_mask),
        .rd_cw    (stored_cw)
    );

    ecc_decoder u_dec (
        .cw_in    (stored_cw),
        .result   (dec_res),
        .raw_data (dec_raw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= '0;
            rvalid  <= 1'b0;
            sec_err <= 1'b0;
            ded_err <= 1'b0;
        end else begin
            rvalid <= do_read;
            if (do_read) begin
                rdata   <= dec_res.data;
                sec_err <= (dec_res.status == ST_SINGLE) || (dec_res.status == ST_OVERALL);
                ded_err <= (dec_res.status == ST_DOUBLE);
            end
        end
    end

    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(sec_err && ded_err));

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!rvalid && !$past(rst)) |-> ($stable(rdata) && $stable(sec_err) && $stable(ded_err)));

    assert_write_read_roundtrip_R2: assert property (@(posedge clk) disable iff (rst)
        (sel && wr) ##1 (sel && !wr && addr == $past(addr)) |=>
        (rvalid && !sec_err && !ded_err && rdata == $past(wdata, 2)));

    assert_uncorrectable_raw_R6: assert property (@(posedge clk) disable iff (rst)
        (dec_res.status == ST_DOUBLE) |-> (dec_res.data == dec_raw));

    assert_at_most_one_fix_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(dec_res.data ^ dec_raw) <= 1);

endmodule

// File: tb/ecc_word_mem_bench.sv
`timescale 1ns/1ps
module ecc_word_mem_bench;
    localparam int AW = 4;
    localparam int NV = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          inj_en = 1'b0;
    logic [12:0]   inj_mask = '0;
    logic [7:0]    rdata;
    logic          rvalid;
    logic          sec_err;
    logic          ded_err;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ecc_word_mem #(.ADDR_W(AW)) u_ecc_word_mem (
        .clk(clk), .rst(rst), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
        .inj_en(inj_en), .inj_mask(inj_mask), .rdata(rdata), .rvalid(rvalid),
        .sec_err(sec_err), .ded_err(ded_err)
    );

    // {data, mask, expected data, expected sec, expected ded}
    localparam logic [30:0] VEC [NV] = '{
        {8'hC4, 13'h0000, 8'hC4, 1'b0, 1'b0},
        {8'hC4, 13'h0001, 8'hC4, 1'b1, 1'b0},
        {8'hC4, 13'h0010, 8'hC4, 1'b1, 1'b0},
        {8'h2E, 13'h0010, 8'h2E, 1'b1, 1'b0},
        {8'h2E, 13'h0800, 8'h2E, 1'b1, 1'b0},
        {8'hA5, 13'h1000, 8'hA5, 1'b1, 1'b0},
        {8'h3C, 13'h0014, 8'hFC, 1'b0, 1'b1},
        {8'h0F, 13'h0900, 8'h06, 1'b0, 1'b1},
        {8'h5A, 13'h0089, 8'h5A, 1'b0, 1'b1},
        {8'h00, 13'h1040, 8'h10, 1'b0, 1'b1},
        {8'hFF, 13'h0080, 8'hFF, 1'b1, 1'b0},
        {8'h96, 13'h008A, 8'h96, 1'b0, 1'b1}
    };
    string TAG [NV] = '{"R2", "R3", "R3", "R3", "R3", "R4",
                        "R1/R5", "R1/R5", "R6", "R1/R5", "R3", "R6"};

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        sel = 1'b0; wr = 1'b0; inj_en = 1'b0; inj_mask = '0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic do_inject(input logic [AW-1:0] a, input logic [12:0] m);
        inj_en = 1'b1; addr = a; inj_mask = m;
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        clear_inputs();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk("R9 rvalid", {15'd0, rvalid}, 16'd0);
        chk("R9 flags", {14'd0, sec_err, ded_err}, 16'd0);
        chk("R9 rdata", {8'd0, rdata}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            logic [30:0] v;
            v = VEC[i];
            do_write(AW'(i), v[30:23]);
            // R7: write does not raise rvalid
            chk("R7 write", {15'd0, rvalid}, 16'd0);
            do_inject(AW'(i), v[22:10]);
            do_read(AW'(i));
            chk({TAG[i], " rvalid"}, {15'd0, rvalid}, 16'd1);
            chk({TAG[i], " data"}, {8'd0, rdata}, {8'd0, v[9:2]});
            chk({TAG[i], " flags"}, {14'd0, sec_err, ded_err}, {14'd0, v[1], v[0]});
            @(negedge clk);
            chk("R7 pulse", {15'd0, rvalid}, 16'd0);
        end

        // R8: sel low blocks writes and outputs hold
        do_write(4'd15, 8'h77);
        sel = 1'b0; wr = 1'b1; addr = 4'd15; wdata = 8'h11;
        @(negedge clk);
        chk("R8 hold data", {8'd0, rdata}, 16'h0096);
        chk("R8 hold flags", {14'd0, sec_err, ded_err}, 16'd1);
        clear_inputs();
        do_read(4'd15);
        chk("R8 no write", {8'd0, rdata}, 16'h0077);

        // R10: write wins over injection in the same cycle, then direct read-back (R2)
        sel = 1'b1; wr = 1'b1; addr = 4'd14; wdata = 8'h33; inj_en = 1'b1; inj_mask = 13'h0010;
        @(negedge clk);
        clear_inputs();
        do_read(4'd14);
        chk("R10 write wins", {8'd0, rdata}, 16'h0033);
        chk("R10 flags", {14'd0, sec_err, ded_err}, 16'd0);

        // R9: reset mid-run clears outputs, keeps array
        do_read(4'd6);
        chk("R5 before reset", {14'd0, sec_err, ded_err}, 16'd1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R9 flags cleared", {14'd0, sec_err, ded_err}, 16'd0);
        chk("R9 rvalid cleared", {15'd0, rvalid}, 16'd0);
        chk("R9 rdata cleared", {8'd0, rdata}, 16'd0);
        do_read(4'd3);
        chk("R9 array kept", {8'd0, rdata}, 16'h002E);
        chk("R9 array kept flags", {14'd0, sec_err, ded_err}, 16'd2);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule